// File: doc/BRIEF.md
# MSI Capture Ring Writer

This block receives message-signalled interrupt writes and stores each one as a 16-byte record in a circular buffer held in system memory. The buffer's location, its size and the software read offset are set through a small word-addressed register port. The hardware write offset advances as records land in memory. An interrupt level stays raised while records are waiting for software, and it can also be raised while the ring is full.

Inbound messages arrive on a valid/ready stream that carries one 32-bit data word. A message is taken on a clock edge where both `msg_valid` and `msg_ready` are high. The block holds `msg_ready` low while one record is still waiting for the memory port. It also holds it low while the ring is full and the stop-when-full policy is on. Records leave on a second valid/ready stream: a 64-bit byte address and a 128-bit entry. Once `mem_valid` is raised, address and data stay unchanged until `mem_ready` is seen high on a clock edge. At most one record is in flight, so the steady rate is one message every two cycles.

Software drains the ring by comparing the masked write offset with its own read offset. It then advances the read offset register in steps of 16 bytes. When software clears the enable and interrupt-enable bits, capture and interrupt signalling stop.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_valid` is low. Unmapped word addresses (1, 2, 7) always read zero.
- R2: Register word addresses are: control 0, base-high 3, base-low 4, read offset 5, write offset 6. Control bits are: 0 enable, 1 full-detect, 3 interrupt-enable, 4 stop-when-full, 9:8 size select. Other control bits read back zero. Writes to the write offset register are ignored.
- R3: For each message taken while enabled, exactly one record is issued. Its address is {base-high, base-low} + masked write offset. Its data carries the message word in bits 31:0 and all ones in bits 127:32.
- R4: `mem_valid`, `mem_addr` and `mem_data` hold until `mem_ready` is seen. `msg_ready` stays low while a record is outstanding. The write offset advances by 16 only on the cycle after the memory port accepts the record.
- R5: While enable is clear, messages are taken (`msg_ready` high) and dropped: no record is issued and the write offset does not change.
- R6: The write offset wraps to zero at the configured ring size and not before.
- R7: The ring is full when ((write offset + 16) & M) equals (read offset & M). While full with enable and stop-when-full set, `msg_ready` is low and no record is issued. Advancing the read offset by 16 releases it.
- R8: Without stop-when-full, a full ring still takes messages and overwrites the oldest record.
- R9: `irq` is high while interrupt-enable is set and the masked write offset differs from the masked read offset.
- R10: `irq` is high while full-detect is set and the ring is full, even with interrupt-enable clear.
- R11: Size select s gives a ring of 2^(15+s) bytes, and M = (2^(15+s) − 1) with bits 3:0 cleared. Full and pending compares use offsets masked by M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| msg_valid | input | 1 | Inbound message valid |
| msg_ready | output | 1 | Inbound message ready |
| msg_data | input | 32 | Inbound message data word |
| mem_valid | output | 1 | Record write request valid |
| mem_ready | input | 1 | Memory accepts the record |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents |
| irq | output | 1 | Interrupt level |

## Verification
A message taken on an edge shows up on the memory port from the next cycle. The write offset and `irq` change one cycle after the edge where the memory port accepts the record. A register write changes `msg_ready` and `irq` from the cycle after its edge, and register reads are combinational. The bench drives every input and samples every output on falling edges, so each check lands one full cycle after the edge that causes the change. The size-0 ring is swept through a complete wrap and a complete fill. Every size select is probed at its mask boundary, and the size-1 ring is driven across the 32 KB point.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int REG_AW        = 3;
  localparam int WORD_W        = 32;
  localparam int ADDR_W        = 2 * WORD_W;
  localparam int ENTRY_W       = 128;
  localparam int ENTRY_BYTES   = ENTRY_W / 8;
  localparam int RING_MIN_LOG2 = 15;
  localparam int SIZE_SEL_W    = 2;

  localparam logic [REG_AW-1:0] A_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] A_BASE_HI = 3'd3;
  localparam logic [REG_AW-1:0] A_BASE_LO = 3'd4;
  localparam logic [REG_AW-1:0] A_RD_OFF  = 3'd5;
  localparam logic [REG_AW-1:0] A_WR_OFF  = 3'd6;

  typedef struct packed {
    logic [SIZE_SEL_W-1:0] size_sel;
    logic                  stop_full;
    logic                  irq_en;
    logic                  full_det;
    logic                  enable;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [WORD_W-1:0] w;
    w      = '0;
    w[0]   = c.enable;
    w[1]   = c.full_det;
    w[3]   = c.irq_en;
    w[4]   = c.stop_full;
    w[9:8] = c.size_sel;
    return w;
  endfunction

  function automatic ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.enable    = w[0];
    c.full_det  = w[1];
    c.irq_en    = w[3];
    c.stop_full = w[4];
    c.size_sel  = w[9:8];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ring_mask(input logic [SIZE_SEL_W-1:0] sel);
    logic [WORD_W-1:0] span;
    span = WORD_W'(1) << (RING_MIN_LOG2 + int'(sel));
    return (span - WORD_W'(1)) & ~WORD_W'(ENTRY_BYTES - 1);
  endfunction
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] wr_off_i,
  output logic [WORD_W-1:0] reg_rdata,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [WORD_W-1:0] rd_off_o
);
  ctrl_t             ctrl_q;
  logic [WORD_W-1:0] base_hi_q;
  logic [WORD_W-1:0] base_lo_q;
  logic [WORD_W-1:0] rd_off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      rd_off_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:    ctrl_q    <= word_to_ctrl(reg_wdata);
        A_BASE_HI: base_hi_q <= reg_wdata;
        A_BASE_LO: base_lo_q <= reg_wdata;
        A_RD_OFF:  rd_off_q  <= reg_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:    reg_rdata = ctrl_to_word(ctrl_q);
      A_BASE_HI: reg_rdata = base_hi_q;
      A_BASE_LO: reg_rdata = base_lo_q;
      A_RD_OFF:  reg_rdata = rd_off_q;
      A_WR_OFF:  reg_rdata = wr_off_i;
      default:   reg_rdata = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign base_o   = {base_hi_q, base_lo_q};
  assign rd_off_o = rd_off_q;

  // R2: the register file never alters control without a write strobe
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(ctrl_q));
endmodule

// File: rtl/msi_ring_ptr.sv
module msi_ring_ptr
  import msi_ring_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SIZE_SEL_W-1:0] size_sel_i,
  input  logic [WORD_W-1:0]     rd_off_i,
  input  logic                  adv_i,
  output logic [WORD_W-1:0]     wr_off_o,
  output logic [WORD_W-1:0]     wr_m_o,
  output logic                  full_o,
  output logic                  pending_o
);
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] wr_q;
  logic [WORD_W-1:0] rd_m;
  logic [WORD_W-1:0] wr_next_m;

  assign mask      = ring_mask(size_sel_i);
  assign wr_m_o    = wr_q & mask;
  assign rd_m      = rd_off_i & mask;
  assign wr_next_m = (wr_m_o + WORD_W'(ENTRY_BYTES)) & mask;

  always_ff @(posedge clk) begin
    if (!rst_n)     wr_q <= '0;
    else if (adv_i) wr_q <= wr_next_m;
  end

  assign full_o    = (wr_next_m == rd_m);
  assign pending_o = (wr_m_o != rd_m);
  assign wr_off_o  = wr_q;

  // R4: the write offset moves only after the memory port took a record
  a_r4_adv_only: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(wr_q));
  // R6: the write offset stays record-aligned
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q[3:0] == 4'd0);
endmodule

// File: rtl/msi_ring_emit.sv
module msi_ring_emit
  import msi_ring_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               stop_full_i,
  input  logic               full_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [WORD_W-1:0]  wr_m_i,
  input  logic               msg_valid_i,
  output logic               msg_ready_o,
  input  logic [WORD_W-1:0]  msg_data_i,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [ENTRY_W-1:0] mem_data_o,
  output logic               adv_o
);
  localparam int PAD_W = ENTRY_W - WORD_W;

  logic               pend_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ENTRY_W-1:0] data_q;
  logic               blocked;
  logic               take;

  assign blocked     = enable_i && stop_full_i && full_i;
  assign msg_ready_o = !pend_q && !blocked;
  assign take        = msg_valid_i && msg_ready_o;
  assign adv_o       = pend_q && mem_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (adv_o) pend_q <= 1'b0;
      if (take && enable_i) begin
        pend_q <= 1'b1;
        addr_q <= base_i + {{(ADDR_W-WORD_W){1'b0}}, wr_m_i};
        data_q <= {{PAD_W{1'b1}}, msg_data_i};
      end
    end
  end

  assign mem_valid_o = pend_q;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = data_q;

  // R4: an offered record is held until the memory port takes it
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));
  // R5: a message taken while disabled produces no record
  a_r5_discard: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_i && msg_ready_o && !enable_i |=> !mem_valid_o);
  // R7: a full ring under the stop policy takes nothing
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i && stop_full_i && full_i |-> !msg_ready_o);
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
  import msi_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         msg_valid,
  output logic         msg_ready,
  input  logic [31:0]  msg_data,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic [63:0]  mem_addr,
  output logic [127:0] mem_data,
  output logic         irq
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] base;
  logic [WORD_W-1:0] rd_off;
  logic [WORD_W-1:0] wr_off;
  logic [WORD_W-1:0] wr_m;
  logic              full;
  logic              pending;
  logic              adv;

  msi_ring_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wr_off_i  (wr_off),
    .reg_rdata (reg_rdata),
    .ctrl_o    (ctrl),
    .base_o    (base),
    .rd_off_o  (rd_off)
  );

  msi_ring_ptr u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_sel_i (ctrl.size_sel),
    .rd_off_i   (rd_off),
    .adv_i      (adv),
    .wr_off_o   (wr_off),
    .wr_m_o     (wr_m),
    .full_o     (full),
    .pending_o  (pending)
  );

  msi_ring_emit u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (ctrl.enable),
    .stop_full_i (ctrl.stop_full),
    .full_i      (full),
    .base_i      (base),
    .wr_m_i      (wr_m),
    .msg_valid_i (msg_valid),
    .msg_ready_o (msg_ready),
    .msg_data_i  (msg_data),
    .mem_valid_o (mem_valid),
    .mem_ready_i (mem_ready),
    .mem_addr_o  (mem_addr),
    .mem_data_o  (mem_data),
    .adv_o       (adv)
  );

  assign irq = (ctrl.irq_en && pending) || (ctrl.full_det && full);

  // R3: every offered record carries the all-ones padding
  a_r3_padding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (&mem_data[127:32]));
  // R10: back-pressure with nothing in flight means full, which must signal when detection is on
  a_r10_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.enable && ctrl.full_det && !msg_ready && !mem_valid |-> irq);
  // R9: the interrupt needs one of its enables
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl.irq_en || ctrl.full_det));
endmodule

// File: tb/msi_ring_writer_tb.sv
`timescale 1ns/1ps
module msi_ring_writer_tb;
  localparam logic [31:0] C_EN = 32'h1, C_FULL = 32'h2, C_IRQ = 32'h8, C_STOP = 32'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic msg_valid = 1'b0;
  logic msg_ready;
  logic [31:0] msg_data = '0;
  logic mem_valid;
  logic mem_ready = 1'b1;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [63:0] base_v;
  logic [31:0] exp_wr;
  logic [31:0] cur_mask;
  logic [31:0] rd_v;
  logic [31:0] v;

  always #4 clk = ~clk;

  msi_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_data(msg_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
  );

  function automatic logic [31:0] mask_of(input int sz);
    return ((32'd1 << (15 + sz)) - 32'd1) & ~32'hF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, input bit wexp, input string tag);
    @(negedge clk);
    while (!msg_ready) @(negedge clk);
    msg_valid = 1'b1; msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
    if (wexp) begin
      chk(mem_valid === 1'b1, tag, mem_valid, 1);
      chk(mem_addr === base_v + {32'd0, exp_wr}, tag, mem_addr, base_v + {32'd0, exp_wr});
      chk(mem_data === {{96{1'b1}}, d}, tag, mem_data, {{96{1'b1}}, d});
      exp_wr = (exp_wr + 32'd16) & cur_mask;
    end else begin
      chk(mem_valid === 1'b0, tag, mem_valid, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    base_v = 64'h0000_0001_8000_0000;
    exp_wr = '0;
    cur_mask = mask_of(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), v);
      chk(v === 32'd0, "R1 reg after reset", v, 0);
    end
    chk(irq === 1'b0, "R1 irq", irq, 0);
    chk(mem_valid === 1'b0, "R1 mem_valid", mem_valid, 0);

    // R2: register map and readback
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, v);
    chk(v === 32'h0000_031B, "R2 ctrl readback", v, 32'h31B);
    reg_write(3'd0, 32'd0);
    reg_write(3'd3, base_v[63:32]);
    reg_write(3'd4, base_v[31:0]);
    reg_read(3'd3, v); chk(v === base_v[63:32], "R2 base hi", v, base_v[63:32]);
    reg_read(3'd4, v); chk(v === base_v[31:0], "R2 base lo", v, base_v[31:0]);
    reg_write(3'd6, 32'h0000_1230);
    reg_read(3'd6, v); chk(v === 32'd0, "R2 wr offset read-only", v, 0);
    reg_write(3'd5, 32'h40);
    reg_read(3'd5, v); chk(v === 32'h40, "R2 rd offset", v, 32'h40);
    reg_write(3'd2, 32'hDEAD_BEEF);
    reg_read(3'd2, v); chk(v === 32'd0, "R1 unmapped", v, 0);
    reg_write(3'd5, 32'd0);

    // R5: disabled, messages dropped
    chk(msg_ready === 1'b1, "R5 ready while disabled", msg_ready, 1);
    push(32'h0000_00AB, 1'b0, "R5 no record");
    chk(mem_valid === 1'b0, "R5 still idle", mem_valid, 0);
    reg_read(3'd6, v); chk(v === 32'd0, "R5 wr unchanged", v, 0);

    // R3/R4: stalled memory port
    reg_write(3'd0, C_EN | C_IRQ);
    mem_ready = 1'b0;
    push(32'h0000_1234, 1'b1, "R3 first record");
    chk(mem_valid === 1'b1, "R4 held valid", mem_valid, 1);
    chk(mem_addr === base_v, "R4 held addr", mem_addr, base_v);
    chk(msg_ready === 1'b0, "R4 ready low while pending", msg_ready, 0);
    reg_read(3'd6, v); chk(v === 32'd0, "R4 no advance before accept", v, 0);
    chk(irq === 1'b0, "R9 nothing landed yet", irq, 0);
    @(negedge clk); mem_ready = 1'b1;
    @(negedge clk);
    chk(mem_valid === 1'b0, "R4 released", mem_valid, 0);
    reg_read(3'd6, v); chk(v === 32'd16, "R4 advance by 16", v, 16);
    chk(irq === 1'b1, "R9 pending raises irq", irq, 1);
    reg_write(3'd5, 32'd16);
    chk(irq === 1'b0, "R9 drained clears irq", irq, 0);

    // R3: varied data patterns
    for (int i = 0; i < 8; i++) push(32'hA5A5_0000 ^ (32'(i) * 32'h0101_1111), 1'b1, "R3 pattern");

    // R6: full wrap of the 32 KB ring without the stop policy
    for (int i = 0; i < 2048; i++) push(32'(i), 1'b1, "R6 sweep");
    reg_read(3'd6, v); chk(v === exp_wr, "R6 wrap size0", v, exp_wr);

    // R7: fill under the stop policy
    rd_v = exp_wr;
    reg_write(3'd5, rd_v);
    reg_write(3'd0, C_EN | C_STOP | C_FULL);
    begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < 4096; i++) begin
        if (!msg_ready) break;
        push(32'h7000_0000 + 32'(i), 1'b1, "R7 fill");
        cnt++;
      end
      chk(cnt == 2047, "R7 records until full", cnt, 2047);
    end
    reg_read(3'd6, v);
    chk(v === ((rd_v - 32'd16) & cur_mask), "R7 wr when full", v, (rd_v - 32'd16) & cur_mask);
    chk(irq === 1'b1, "R10 full irq without irq_en", irq, 1);
    @(negedge clk); msg_valid = 1'b1; msg_data = 32'hBAD;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(msg_ready === 1'b0, "R7 back-pressure", msg_ready, 0);
      chk(mem_valid === 1'b0, "R7 no record", mem_valid, 0);
    end
    msg_valid = 1'b0;
    rd_v = (rd_v + 32'd16) & cur_mask;
    reg_write(3'd5, rd_v);
    chk(msg_ready === 1'b1, "R7 released", msg_ready, 1);
    chk(irq === 1'b0, "R10 not full no irq", irq, 0);

    // R8: overwrite without stop
    reg_write(3'd0, C_EN | C_FULL);
    rd_v = (exp_wr + 32'd16) & cur_mask;
    reg_write(3'd5, rd_v);
    chk(irq === 1'b1, "R10 full again", irq, 1);
    chk(msg_ready === 1'b1, "R8 full still ready", msg_ready, 1);
    push(32'h0000_0808, 1'b1, "R8 overwrite");
    reg_read(3'd6, v); chk(v === rd_v, "R8 wr reaches rd", v, rd_v);
    chk(irq === 1'b0, "R8 equal offsets no irq", irq, 0);

    // R11: mask per size select
    for (int sz = 0; sz < 4; sz++) begin
      reg_write(3'd0, C_EN | C_STOP | C_IRQ | (32'(sz) << 8));
      reg_write(3'd5, exp_wr + 32'd16 + (32'd1 << (15 + sz)));
      chk(msg_ready === 1'b0, "R11 full at size alias", msg_ready, 0);
      reg_write(3'd5, exp_wr + 32'd16 + (32'd1 << (14 + sz)));
      chk(msg_ready === 1'b1, "R11 half-size not full", msg_ready, 1);
      chk(irq === 1'b1, "R11 pending irq", irq, 1);
    end

    // R6: 64 KB ring does not wrap at 32 KB
    reg_write(3'd0, C_EN | (32'd1 << 8));
    cur_mask = mask_of(1);
    begin
      int n;
      n = int'((32'h8000 - exp_wr) / 32'd16) + 1;
      for (int i = 0; i < n; i++) push(32'h6000_0000 + 32'(i), 1'b1, "R6 size1 cross");
    end
    reg_read(3'd6, v);
    chk(v === 32'h8010, "R6 size1 past 32K", v, 32'h8010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule